// File: doc/BRIEF.md
# Four-Channel Compare Timer with Sticky Watchdog

This block is a free-running up-counter shared by four compare channels. Each time the tick input is high the counter advances by one. When the counter steps onto the value held in a channel's compare register, that channel's event flag is set. The flag is driven onto the channel's interrupt line when the channel's interrupt enable is on. Software clears a flag by writing a 1 to its position.

A watchdog arm bit can be set by software but never cleared by it; only a block reset clears it. Once the arm bit is set, an event on channel 3 raises a reset request for one cycle. The block is programmed through a simple single-cycle register port with a combinational read path. The asynchronous active-low reset is released synchronously inside the block.

Top module: `match_timer_wdog`

## Requirements
- R1: After reset, every readable register reads 0, all interrupt lines are low and the reset request is low.
- R2: The counter (address 4) grows by exactly one on each cycle with the tick input high and keeps its value on cycles with the tick input low.
- R3: The counter steps from all ones to zero, and that step sets no event flag unless a compare register holds zero.
- R4: A write to address 4 loads the counter with the write data and overrides a tick in the same cycle. A loaded value never produces an event.
- R5: Event flag n (bit n of address 5) becomes set at the clock edge where a tick moves the counter onto the value of compare register n (address n, for n from 0 to 3). Writing a compare register to the counter's present value sets nothing.
- R6: Writing address 5 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If an event on a channel coincides with a clear of that channel, the flag stays set.
- R7: Interrupt line n is high exactly when flag n is set and enable bit n of address 6 is 1.
- R8: Writing 1 to bit 0 of address 7 sets the watchdog arm bit. Writing 0 leaves it unchanged, and only a block reset clears it.
- R9: With the arm bit set, an event on channel 3 drives the reset request high for exactly one cycle, in the same cycle that flag 3 first reads set. Without the arm bit set, the reset request stays low.
- R10: Compare registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| irq_o | output | 4 | Per-channel interrupt lines |
| wdog_rst_o | output | 1 | Watchdog reset request |

## Verification
The bench steps the counter across the all-ones boundary with no compare register at zero. A design that flagged wraparound would show a stray event bit there. It loads the counter and the compare registers to values equal to the present count, to catch a design that compares levels instead of detecting the tick step. A comparator placed one cycle late would show the flag a cycle after the count. The bench also drives a tick onto a compare value in the same cycle as a clear of that flag; a design that gives the clear priority loses the event. For the watchdog, it writes 0 after arming to catch an arm bit that software can clear. It counts reset-request cycles to catch a request that is missing or that lasts longer than one cycle, and it fires channel 3 while unarmed to catch a request raised without the arm bit.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned WDOG_CH = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMP0   = 3'd0,
    REG_CMP1   = 3'd1,
    REG_CMP2   = 3'd2,
    REG_CMP3   = 3'd3,
    REG_COUNT  = 3'd4,
    REG_FLAGS  = 3'd5,
    REG_IRQEN  = 3'd6,
    REG_WDARM  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/mtw_rst_sync.sv
module mtw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/mtw_counter.sv
module mtw_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_inc_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Plus-one value; wraps silently at all ones.
  assign cnt_inc_o = cnt_q + {{(W-1){1'b0}}, 1'b1};
  // A step is a tick-driven advance; a load never counts as one.
  assign step_o    = tick_i & ~load_i;
  assign cnt_en    = tick_i | load_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_inc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mtw_cmp_chan.sv
module mtw_cmp_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_inc_i,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic         ien_i,
  output logic [W-1:0] cmp_o,
  output logic         flag_o,
  output logic         irq_o,
  output logic         hit_o
);
  logic [W-1:0] cmp_q;
  logic         flag_q;
  logic         flag_d;
  logic         flag_en;

  // Event only when a tick carries the counter onto the compare value.
  assign hit_o = step_i & (cnt_inc_i == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= wdata_i;
  end

  // A new event outranks a clear in the same cycle.
  always_comb begin
    flag_en = hit_o | clr_i;
    flag_d  = hit_o | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_i;
endmodule

// File: rtl/mtw_wdog.sv
module mtw_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set_i,
  input  logic hit_i,
  output logic armed_o,
  output logic rst_req_o
);
  logic arm_q;
  logic req_q;
  logic req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         arm_q <= 1'b0;
    else if (arm_set_i) arm_q <= 1'b1;
  end

  // Uses the arm state from before this edge.
  always_comb begin
    req_d = arm_q & hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign armed_o   = arm_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/match_timer_wdog.sv
module match_timer_wdog
  import mtw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              wdog_rst_o
);
  logic              rst_sync_n;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic              cnt_step;
  logic [CNT_W-1:0]  cmp_val [NUM_CH];
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] ien_q;
  logic              arm_q;
  logic              wr_flags;
  logic              wr_ien;
  logic              wr_arm;

  mtw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cnt_load = reg_wr_i & (reg_addr_i == REG_COUNT);
  assign wr_flags = reg_wr_i & (reg_addr_i == REG_FLAGS);
  assign wr_ien   = reg_wr_i & (reg_addr_i == REG_IRQEN);
  assign wr_arm   = reg_wr_i & (reg_addr_i == REG_WDARM) & reg_wdata_i[0];

  mtw_counter #(.W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (cnt_load),
    .load_val_i (reg_wdata_i),
    .cnt_o      (cnt_q),
    .cnt_inc_o  (cnt_inc),
    .step_o     (cnt_step)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ien_q <= '0;
    else if (wr_ien)  ien_q <= reg_wdata_i[NUM_CH-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic cmp_wr;
    assign cmp_wr = reg_wr_i & (reg_addr_i == ADDR_W'(ch));

    mtw_cmp_chan #(.W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .cmp_wr_i  (cmp_wr),
      .wdata_i   (reg_wdata_i),
      .cnt_inc_i (cnt_inc),
      .step_i    (cnt_step),
      .clr_i     (wr_flags & reg_wdata_i[ch]),
      .ien_i     (ien_q[ch]),
      .cmp_o     (cmp_val[ch]),
      .flag_o    (flag_q[ch]),
      .irq_o     (irq_o[ch]),
      .hit_o     (hit[ch])
    );
  end

  mtw_wdog u_wdog (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .arm_set_i (wr_arm),
    .hit_i     (hit[WDOG_CH]),
    .armed_o   (arm_q),
    .rst_req_o (wdog_rst_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CMP0:  reg_rdata_o = cmp_val[0];
      REG_CMP1:  reg_rdata_o = cmp_val[1];
      REG_CMP2:  reg_rdata_o = cmp_val[2];
      REG_CMP3:  reg_rdata_o = cmp_val[3];
      REG_COUNT: reg_rdata_o = cnt_q;
      REG_FLAGS: reg_rdata_o = CNT_W'(flag_q);
      REG_IRQEN: reg_rdata_o = CNT_W'(ien_q);
      REG_WDARM: reg_rdata_o = CNT_W'(arm_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mtw_checker.sv
module mtw_checker
  import mtw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [CNT_W-1:0]  reg_wdata_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [NUM_CH-1:0] flag_q,
  input logic              arm_q,
  input logic              wdog_rst_o
);
  logic load_w;
  logic flag_w;
  assign load_w = reg_wr_i && (reg_addr_i == REG_COUNT);
  assign flag_w = reg_wr_i && (reg_addr_i == REG_FLAGS);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_w) |=> (cnt_q == $past(cnt_q) + 32'd1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_w) |=> $stable(cnt_q));

  assert_count_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (cnt_q == $past(reg_wdata_i)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[ch]) |-> $past(tick_i && !load_w));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_w && reg_wdata_i[ch] && !tick_i) |=> !flag_q[ch]);
  end

  assert_arm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);

  assert_wdog_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> ($past(arm_q) && flag_q[WDOG_CH]));
endmodule

bind match_timer_wdog mtw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cnt_q       (cnt_q),
  .flag_q      (flag_q),
  .arm_q       (arm_q),
  .wdog_rst_o  (wdog_rst_o)
);

// File: tb/match_timer_wdog_test.sv
module match_timer_wdog_test;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        reg_wr_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [3:0]  irq_o;
  logic        wdog_rst_o;

  int checks;
  int fails;
  int req_cycles;
  logic [31:0] rv;

  match_timer_wdog uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .wdog_rst_o  (wdog_rst_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (wdog_rst_o) req_cycles++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv); chk("R1 reg after reset", rv, 32'd0);
    end
    chk("R1 irq after reset", {28'd0, irq_o}, 32'd0);
    chk("R1 wdog req after reset", {31'd0, wdog_rst_o}, 32'd0);
  endtask

  task automatic t_setup();
    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0000_5000);
    wr(3'd2, 32'h0000_2000);
    wr(3'd3, 32'h0000_3000);
    rd(3'd0, rv); chk("R10 cmp0 readback", rv, 32'h1000);
    rd(3'd3, rv); chk("R10 cmp3 readback", rv, 32'h3000);
  endtask

  task automatic t_count();
    wr(3'd4, 32'd10);
    ticks(5);
    rd(3'd4, rv); chk("R2 five ticks", rv, 32'd15);
    repeat (3) @(negedge clk);
    rd(3'd4, rv); chk("R2 hold without tick", rv, 32'd15);
  endtask

  task automatic t_wrap();
    wr(3'd4, 32'hFFFF_FFFE);
    ticks(3);
    rd(3'd4, rv); chk("R3 wrap value", rv, 32'd1);
    rd(3'd5, rv); chk("R3 no flag on wrap", rv, 32'd0);
  endtask

  task automatic t_load();
    @(negedge clk);
    tick_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 32'd50;
    @(negedge clk);
    tick_i = 1'b0; reg_wr_i = 1'b0;
    rd(3'd4, rv); chk("R4 load beats tick", rv, 32'd50);
    wr(3'd4, 32'h1000);
    rd(3'd5, rv); chk("R4 load onto cmp0 no flag", rv, 32'd0);
  endtask

  task automatic t_match();
    wr(3'd4, 32'h0FFE);
    ticks(1);
    chk("R5 no flag one short", {28'd0, irq_o}, 32'd0);
    rd(3'd5, rv); chk("R5 flag clear one short", rv, 32'd0);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    reg_addr_i = 3'd5;
    #1 chk("R5 flag0 with count", reg_rdata_o, 32'd1);
    wr(3'd1, 32'h1000);
    repeat (2) @(negedge clk);
    rd(3'd5, rv); chk("R5 cmp write equal count no flag", rv, 32'd1);
    wr(3'd1, 32'h5000);
  endtask

  task automatic t_irq();
    chk("R7 irq off while disabled", {28'd0, irq_o}, 32'd0);
    wr(3'd6, 32'h1);
    #1 chk("R7 irq0 enabled", {28'd0, irq_o}, 32'd1);
    wr(3'd6, 32'hE);
    #1 chk("R7 other enables only", {28'd0, irq_o}, 32'd0);
  endtask

  task automatic t_clear();
    wr(3'd5, 32'h0);
    rd(3'd5, rv); chk("R6 zero write keeps", rv, 32'd1);
    wr(3'd5, 32'h1);
    rd(3'd5, rv); chk("R6 one write clears", rv, 32'd0);
    wr(3'd4, 32'h1FFF);
    ticks(1);
    rd(3'd5, rv); chk("R5 flag2 set", rv, 32'd4);
    wr(3'd4, 32'h1FFF);
    @(negedge clk);
    tick_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 3'd5; reg_wdata_i = 32'h4;
    @(negedge clk);
    tick_i = 1'b0; reg_wr_i = 1'b0;
    rd(3'd5, rv); chk("R6 event beats clear", rv, 32'd4);
    wr(3'd5, 32'hF);
    rd(3'd5, rv); chk("R6 clear all", rv, 32'd0);
  endtask

  task automatic t_wdog();
    wr(3'd7, 32'h0);
    rd(3'd7, rv); chk("R8 zero write no arm", rv, 32'd0);
    req_cycles = 0;
    wr(3'd4, 32'h2FFF);
    ticks(1);
    rd(3'd5, rv); chk("R9 flag3 unarmed", rv, 32'd8);
    chk("R9 no request unarmed", req_cycles, 32'd0);
    wr(3'd5, 32'hF);
    wr(3'd7, 32'h1);
    rd(3'd7, rv); chk("R8 armed", rv, 32'd1);
    wr(3'd7, 32'h0);
    rd(3'd7, rv); chk("R8 sticky", rv, 32'd1);
    wr(3'd4, 32'h2FFF);
    ticks(1);
    chk("R9 request with flag", {31'd0, wdog_rst_o}, 32'd1);
    reg_addr_i = 3'd5;
    #1 chk("R9 flag3 same cycle", reg_rdata_o, 32'd8);
    @(negedge clk);
    chk("R9 request dropped", {31'd0, wdog_rst_o}, 32'd0);
    chk("R9 one request cycle", req_cycles, 32'd1);
    do_reset();
    rd(3'd7, rv); chk("R8 reset disarms", rv, 32'd0);
  endtask

  initial begin
    checks = 0; fails = 0; req_cycles = 0;
    tick_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = 3'd0; reg_wdata_i = 32'd0;
    rst_n = 1'b0;
    do_reset();
    t_reset();
    t_setup();
    t_count();
    t_wrap();
    t_load();
    t_match();
    t_irq();
    t_clear();
    t_wdog();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule